// File: doc/BRIEF.md
# Integer ALU with Shifter

A purely combinational 32-bit arithmetic and logic unit for the execute stage of a small load/store RISC core. Each cycle it takes two register operands, a 16-bit immediate, a 5-bit constant shift count and a 5-bit operation code. From these it produces one 32-bit result, a flag that marks an all-zero result, and a flag that marks signed overflow. The instruction decoder outside the block picks the operation code. It also places the immediate and the constant shift count on their own ports, so the block itself never parses an instruction word.

The operation set covers the following:
- wrapping and overflow-reporting add and subtract, including immediate forms;
- the four bitwise functions AND, OR, XOR and NOR;
- signed and unsigned less-than tests that return 0 or 1;
- three kinds of shift, each with either a constant count or a count taken from a register;
- placement of the immediate in the upper half of the word.

The branch-equal path subtracts the two operands and then tests the zero flag.

Top module: `alu_core`

## Requirements
- R1: Codes 0 (ADD), 1 (ADDU), 2 (SUB) and 3 (SUBU) return A+B or A−B modulo 2^32 on `result_o`.
- R2: Codes 0 (ADD), 2 (SUB) and 16 (ADDI) raise `ovf_o` exactly when the two addends (B inverted for subtract) share a sign and the 32-bit result has the other sign.
- R3: Every code other than 0, 2 and 16 leaves `ovf_o` at 0, and this includes the wrapping forms 1, 3 and 17 (ADDIU).
- R4: Codes 4 (AND), 5 (OR), 6 (XOR) and 7 (NOR) apply the bitwise function to A and B. NOR returns ~(A|B).
- R5: Codes 8 (SLT, signed) and 9 (SLTU, unsigned) return 1 when A < B and 0 otherwise. Bits 31:1 are always 0.
- R6: Codes 16 (ADDI), 17 (ADDIU), 18 (SLTI) and 19 (SLTIU) use `imm_i` sign-extended to 32 bits in place of B. Codes 20 (ANDI), 21 (ORI) and 22 (XORI) use `imm_i` zero-extended. SLTIU compares the sign-extended value as unsigned.
- R7: Codes 10 (SLL), 11 (SRL) and 12 (SRA) shift B by `shamt_i`. SLL and SRL fill with zeros. SRA copies bit 31 of B into the vacated bits. A count of 0 returns B unchanged.
- R8: Codes 13 (SLLV), 14 (SRLV) and 15 (SRAV) shift B in the same way, but the count is A[4:0]. A[31:5] has no effect.
- R9: Code 23 (LUI) returns {imm_i, 16'h0000} and ignores A and B.
- R10: `zero_o` is 1 exactly when `result_o` is 0. After SUB or SUBU it is 1 exactly when A equals B.
- R11: Codes 24 to 31 are unused. They return 0 with `zero_o`=1 and `ovf_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First register operand; A[4:0] is the count for the variable shifts |
| b_i | input | 32 | Second register operand; the value that all shifts operate on |
| imm_i | input | 16 | Immediate field for the immediate forms and LUI |
| shamt_i | input | 5 | Constant shift count |
| op_i | input | 5 | Operation code (see requirements) |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result equals zero |
| ovf_o | output | 1 | Signed overflow of the reporting add/subtract forms |

## Verification
The block holds no registers, so the result and both flags settle in the same cycle as their inputs, and all three are due zero cycles after a stimulus. The bench applies each operand set on a falling clock edge. It samples all three outputs one time unit after the next rising edge, when the inputs have been stable for half a period. It then compares them against a behavioural model that uses wide signed arithmetic and native shift operators. Directed vectors cover the overflow boundaries, sign and zero extension, counts of 0 and 31, and the unused codes. A long run of random operand sets then covers every code in the same way.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
    localparam int XLEN  = 32;
    localparam int SHW   = $clog2(XLEN);
    localparam int IMMW  = 16;
    localparam int OPW   = 5;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB   = 5'd2,  OP_SUBU  = 5'd3,
        OP_AND   = 5'd4,  OP_OR    = 5'd5,  OP_XOR   = 5'd6,  OP_NOR   = 5'd7,
        OP_SLT   = 5'd8,  OP_SLTU  = 5'd9,  OP_SLL   = 5'd10, OP_SRL   = 5'd11,
        OP_SRA   = 5'd12, OP_SLLV  = 5'd13, OP_SRLV  = 5'd14, OP_SRAV  = 5'd15,
        OP_ADDI  = 5'd16, OP_ADDIU = 5'd17, OP_SLTI  = 5'd18, OP_SLTIU = 5'd19,
        OP_ANDI  = 5'd20, OP_ORI   = 5'd21, OP_XORI  = 5'd22, OP_LUI   = 5'd23
    } alu_op_e;

    typedef enum logic [1:0] {BW_AND, BW_OR, BW_XOR, BW_NOR} bw_fn_e;
    typedef enum logic [1:0] {SH_LEFT, SH_RLOG, SH_RARITH} sh_kind_e;
    typedef enum logic [2:0] {SRC_NONE, SRC_SUM, SRC_LTS, SRC_LTU, SRC_BW, SRC_SH, SRC_UPPER} src_e;

    typedef struct packed {
        logic     use_imm;
        logic     imm_sext;
        logic     do_sub;
        logic     trap;
        logic     var_amt;
        sh_kind_e sh_kind;
        bw_fn_e   bw_fn;
        src_e     src;
    } ctrl_t;

    function automatic ctrl_t decode_op(logic [OPW-1:0] code);
        ctrl_t c;
        c = '{use_imm: 1'b0, imm_sext: 1'b0, do_sub: 1'b0, trap: 1'b0, var_amt: 1'b0,
              sh_kind: SH_LEFT, bw_fn: BW_AND, src: SRC_NONE};
        case (alu_op_e'(code))
            OP_ADD:   begin c.src = SRC_SUM; c.trap = 1'b1; end
            OP_ADDU:  c.src = SRC_SUM;
            OP_SUB:   begin c.src = SRC_SUM; c.do_sub = 1'b1; c.trap = 1'b1; end
            OP_SUBU:  begin c.src = SRC_SUM; c.do_sub = 1'b1; end
            OP_AND:   begin c.src = SRC_BW; c.bw_fn = BW_AND; end
            OP_OR:    begin c.src = SRC_BW; c.bw_fn = BW_OR; end
            OP_XOR:   begin c.src = SRC_BW; c.bw_fn = BW_XOR; end
            OP_NOR:   begin c.src = SRC_BW; c.bw_fn = BW_NOR; end
            OP_SLT:   begin c.src = SRC_LTS; c.do_sub = 1'b1; end
            OP_SLTU:  begin c.src = SRC_LTU; c.do_sub = 1'b1; end
            OP_SLL:   begin c.src = SRC_SH; c.sh_kind = SH_LEFT; end
            OP_SRL:   begin c.src = SRC_SH; c.sh_kind = SH_RLOG; end
            OP_SRA:   begin c.src = SRC_SH; c.sh_kind = SH_RARITH; end
            OP_SLLV:  begin c.src = SRC_SH; c.sh_kind = SH_LEFT;   c.var_amt = 1'b1; end
            OP_SRLV:  begin c.src = SRC_SH; c.sh_kind = SH_RLOG;   c.var_amt = 1'b1; end
            OP_SRAV:  begin c.src = SRC_SH; c.sh_kind = SH_RARITH; c.var_amt = 1'b1; end
            OP_ADDI:  begin c.src = SRC_SUM; c.use_imm = 1'b1; c.imm_sext = 1'b1; c.trap = 1'b1; end
            OP_ADDIU: begin c.src = SRC_SUM; c.use_imm = 1'b1; c.imm_sext = 1'b1; end
            OP_SLTI:  begin c.src = SRC_LTS; c.use_imm = 1'b1; c.imm_sext = 1'b1; c.do_sub = 1'b1; end
            OP_SLTIU: begin c.src = SRC_LTU; c.use_imm = 1'b1; c.imm_sext = 1'b1; c.do_sub = 1'b1; end
            OP_ANDI:  begin c.src = SRC_BW; c.use_imm = 1'b1; c.bw_fn = BW_AND; end
            OP_ORI:   begin c.src = SRC_BW; c.use_imm = 1'b1; c.bw_fn = BW_OR; end
            OP_XORI:  begin c.src = SRC_BW; c.use_imm = 1'b1; c.bw_fn = BW_XOR; end
            OP_LUI:   c.src = SRC_UPPER;
            default:  c.src = SRC_NONE;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
    parameter int W = alu_pkg::XLEN
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o,
    output logic         lt_s_o,
    output logic         lt_u_o
);
    logic [W-1:0] b_x;
    logic [W:0]   full;

    assign b_x   = sub_i ? ~b_i : b_i;
    assign full  = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, sub_i};
    assign sum_o = full[W-1:0];
    assign ovf_o = (a_i[W-1] == b_x[W-1]) && (sum_o[W-1] != a_i[W-1]);
    assign lt_s_o = sum_o[W-1] ^ ovf_o;
    assign lt_u_o = ~full[W];

    always_comb begin
        if (sub_i && sum_o == '0) begin
            p_equal_on_zero_r10: assert (a_i == b_i)
                else $error("difference zero with unequal operands");
        end
    end
endmodule

// File: rtl/alu_bitwise.sv
`timescale 1ns/1ps
module alu_bitwise #(
    parameter int W = alu_pkg::XLEN
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  alu_pkg::bw_fn_e fn_i,
    output logic [W-1:0]    y_o
);
    always_comb begin
        case (fn_i)
            alu_pkg::BW_AND: y_o = a_i & b_i;
            alu_pkg::BW_OR:  y_o = a_i | b_i;
            alu_pkg::BW_XOR: y_o = a_i ^ b_i;
            default:         y_o = ~(a_i | b_i);
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
`timescale 1ns/1ps
module alu_shift #(
    parameter int W  = alu_pkg::XLEN,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]      value_i,
    input  logic [SW-1:0]     amt_i,
    input  alu_pkg::sh_kind_e kind_i,
    output logic [W-1:0]      y_o
);
    logic         left;
    logic         fill;
    logic [W-1:0] value_rev;
    logic [W-1:0] stage [SW+1];
    logic [W-1:0] out_rev;

    assign left = (kind_i == alu_pkg::SH_LEFT);
    assign fill = (kind_i == alu_pkg::SH_RARITH) & value_i[W-1];

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign value_rev[i] = value_i[W-1-i];
        assign out_rev[i]   = stage[SW][W-1-i];
    end

    assign stage[0] = left ? value_rev : value_i;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt_i[k] ? {{STEP{fill}}, stage[k][W-1:STEP]} : stage[k];
    end

    assign y_o = left ? out_rev : stage[SW];

    always_comb begin
        if (amt_i == '0) begin
            p_zero_count_r7: assert (y_o == value_i)
                else $error("zero count changed the value");
        end
        if (amt_i != '0 && kind_i == alu_pkg::SH_RARITH) begin
            p_sign_fill_r7: assert (y_o[W-1] == value_i[W-1])
                else $error("arithmetic shift lost the sign");
        end
        if (amt_i != '0 && kind_i == alu_pkg::SH_RLOG) begin
            p_zero_fill_r7: assert (y_o[W-1] == 1'b0)
                else $error("logical right shift did not clear the top bit");
        end
    end
endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core #(
    parameter int W    = alu_pkg::XLEN,
    parameter int IMMW = alu_pkg::IMMW,
    parameter int OPW  = alu_pkg::OPW,
    parameter int SW   = $clog2(W)
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic [SW-1:0]   shamt_i,
    input  logic [OPW-1:0]  op_i,
    output logic [W-1:0]    result_o,
    output logic            zero_o,
    output logic            ovf_o
);
    import alu_pkg::*;

    localparam int EXTW = W - IMMW;

    ctrl_t        ctl;
    logic [W-1:0] imm_ext;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum;
    logic         ovf_raw;
    logic         lt_s;
    logic         lt_u;
    logic [W-1:0] bw_y;
    logic [W-1:0] sh_y;
    logic [SW-1:0] sh_amt;

    assign ctl     = decode_op(op_i);
    assign imm_ext = {{EXTW{ctl.imm_sext & imm_i[IMMW-1]}}, imm_i};
    assign b_eff   = ctl.use_imm ? imm_ext : b_i;
    assign sh_amt  = ctl.var_amt ? a_i[SW-1:0] : shamt_i;

    alu_addsub #(.W(W)) u_addsub (
        .a_i(a_i), .b_i(b_eff), .sub_i(ctl.do_sub),
        .sum_o(sum), .ovf_o(ovf_raw), .lt_s_o(lt_s), .lt_u_o(lt_u)
    );

    alu_bitwise #(.W(W)) u_bitwise (
        .a_i(a_i), .b_i(b_eff), .fn_i(ctl.bw_fn), .y_o(bw_y)
    );

    alu_shift #(.W(W), .SW(SW)) u_shift (
        .value_i(b_i), .amt_i(sh_amt), .kind_i(ctl.sh_kind), .y_o(sh_y)
    );

    always_comb begin
        case (ctl.src)
            SRC_SUM:   result_o = sum;
            SRC_LTS:   result_o = {{(W-1){1'b0}}, lt_s};
            SRC_LTU:   result_o = {{(W-1){1'b0}}, lt_u};
            SRC_BW:    result_o = bw_y;
            SRC_SH:    result_o = sh_y;
            SRC_UPPER: result_o = {imm_i, {EXTW{1'b0}}};
            default:   result_o = '0;
        endcase
    end

    assign zero_o = (result_o == '0);
    assign ovf_o  = ctl.trap & ovf_raw;

    always_comb begin
        if (!ctl.trap) begin
            p_no_overflow_r3: assert (!ovf_o) else $error("overflow on a non-reporting code");
        end
        if (ctl.src == SRC_LTS || ctl.src == SRC_LTU) begin
            p_compare_width_r5: assert (result_o[W-1:1] == '0) else $error("compare result wider than one bit");
        end
        if (ctl.src == SRC_UPPER) begin
            p_upper_low_clear_r9: assert (result_o[EXTW-1:0] == '0) else $error("upper immediate left low bits set");
        end
        if (ctl.src == SRC_NONE) begin
            p_unused_quiet_r11: assert (zero_o && !ovf_o) else $error("unused code not quiet");
        end
    end
endmodule

// File: tb/alu_core_tb.sv
`timescale 1ns/1ps
module alu_core_tb_top;
    logic        clk = 1'b0;
    logic [31:0] a, b;
    logic [15:0] imm;
    logic [4:0]  shamt;
    logic [4:0]  op;
    logic [31:0] result;
    logic        zero, ovf;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #4 clk = ~clk;

    alu_core dut_i (
        .a_i(a), .b_i(b), .imm_i(imm), .shamt_i(shamt), .op_i(op),
        .result_o(result), .zero_o(zero), .ovf_o(ovf)
    );

    function automatic logic [33:0] model(logic [4:0] c, logic [31:0] x, logic [31:0] y,
                                          logic [15:0] im, logic [4:0] sh);
        logic [31:0] r, se, ze;
        logic        v;
        longint      s;
        se = {{16{im[15]}}, im};
        ze = {16'h0, im};
        r = 0; v = 0;
        case (c)
            0, 1:   begin r = x + y; s = longint'($signed(x)) + longint'($signed(y)); v = (c == 0) && (s > 64'sd2147483647 || s < -64'sd2147483648); end
            2, 3:   begin r = x - y; s = longint'($signed(x)) - longint'($signed(y)); v = (c == 2) && (s > 64'sd2147483647 || s < -64'sd2147483648); end
            16, 17: begin r = x + se; s = longint'($signed(x)) + longint'($signed(se)); v = (c == 16) && (s > 64'sd2147483647 || s < -64'sd2147483648); end
            4:  r = x & y;
            5:  r = x | y;
            6:  r = x ^ y;
            7:  r = ~(x | y);
            8:  r = ($signed(x) < $signed(y)) ? 1 : 0;
            9:  r = (x < y) ? 1 : 0;
            18: r = ($signed(x) < $signed(se)) ? 1 : 0;
            19: r = (x < se) ? 1 : 0;
            10: r = y << sh;
            11: r = y >> sh;
            12: r = $signed(y) >>> sh;
            13: r = y << x[4:0];
            14: r = y >> x[4:0];
            15: r = $signed(y) >>> x[4:0];
            20: r = x & ze;
            21: r = x | ze;
            22: r = x ^ ze;
            23: r = {im, 16'h0};
            default: r = 0;
        endcase
        return {v, (r == 0), r};
    endfunction

    function automatic string tag_of(logic [4:0] c);
        case (c)
            0, 1, 2, 3:         return "R1";
            4, 5, 6, 7:         return "R4";
            8, 9:               return "R5";
            16, 17, 18, 19, 20, 21, 22: return "R6";
            10, 11, 12:         return "R7";
            13, 14, 15:         return "R8";
            23:                 return "R9";
            default:            return "R11";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run(logic [4:0] c, logic [31:0] x, logic [31:0] y, logic [15:0] im, logic [4:0] sh);
        logic [33:0] e;
        @(negedge clk);
        op = c; a = x; b = y; imm = im; shamt = sh;
        e = model(c, x, y, im, sh);
        @(posedge clk);
        #1;
        check(tag_of(c), "result", result, e[31:0]);
        check("R10", "zero", {31'h0, zero}, {31'h0, e[32]});
        check((c == 0 || c == 2 || c == 16) ? "R2" : "R3", "ovf", {31'h0, ovf}, {31'h0, e[33]});
    endtask

    initial begin
        op = 5'd31; a = 0; b = 0; imm = 0; shamt = 0;
        @(posedge clk); #1;
        check("R11", "idle result", result, 32'h0);
        // R1 / R2 / R3 overflow boundaries
        run(0,  32'h7fffffff, 32'h1, 0, 0);
        run(1,  32'h7fffffff, 32'h1, 0, 0);
        run(0,  32'h80000000, 32'h80000000, 0, 0);
        run(2,  32'h80000000, 32'h1, 0, 0);
        run(3,  32'h80000000, 32'h1, 0, 0);
        run(2,  32'h12345678, 32'h12345678, 0, 0);   // R10 equal operands
        run(3,  32'h5, 32'h6, 0, 0);
        // R6 immediates
        run(16, 32'h80000000, 0, 16'hffff, 0);
        run(17, 32'h80000000, 0, 16'hffff, 0);
        run(18, 32'hfffffffe, 0, 16'hffff, 0);
        run(19, 32'h00000005, 0, 16'hffff, 0);
        run(20, 32'hffffffff, 0, 16'h8001, 0);
        run(21, 32'h0, 0, 16'hf00f, 0);
        run(22, 32'hffff0000, 0, 16'hffff, 0);
        // R4 / R5
        run(7,  32'h0f0f0000, 32'h00000f0f, 0, 0);
        run(8,  32'hffffffff, 32'h1, 0, 0);
        run(9,  32'hffffffff, 32'h1, 0, 0);
        run(8,  32'h3, 32'h3, 0, 0);
        // R7 / R8 shifts
        run(12, 0, 32'h80000000, 0, 31);
        run(11, 0, 32'h80000000, 0, 31);
        run(10, 0, 32'h00000001, 0, 31);
        run(12, 0, 32'h80000010, 0, 0);
        run(13, 32'hffffffe4, 32'h0000000f, 0, 9);
        run(15, 32'h12345661, 32'h90000000, 0, 3);
        run(14, 32'hffffffe0, 32'hdeadbeef, 0, 7);
        // R9 / R11
        run(23, 32'hffffffff, 32'hffffffff, 16'hbeef, 0);
        run(24, 32'hffffffff, 32'h1, 16'h1, 1);
        run(31, 32'h7fffffff, 32'h7fffffff, 16'hffff, 31);
        for (int i = 0; i < 3000; i++) begin
            run(5'($urandom_range(0, 31)), $urandom, (i % 7 == 0) ? 32'h0 : $urandom,
                16'($urandom), 5'($urandom));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule